// File: doc/BRIEF.md
# Interrupt Pin Capture and Message Dispatch

This block watches a bank of interrupt input lines and turns pin activity into interrupt messages. Every pin is described by a configuration entry supplied from outside: a vector, a delivery mode, a destination mode, a destination index, a trigger mode and a mask. The block holds a pending-request bit and a remote-IRR bit for each pin. It decides when a pin is owed a message and encodes that message as a 32-bit address and a 32-bit data word.

Messages leave on a single valid/ready port, one at a time. When several pins are eligible, the lowest-numbered pin goes first. A level pin that has been serviced stays quiet until a neighbouring end-of-interrupt block clears its remote-IRR bit through a strobe. A second strobe lets a neighbour start a new scan, for example after it changes a pin's mask.

Top module: `irq_dispatch`

## Requirements
- R1: After a synchronous active-low reset, every pending bit, every remote-IRR bit and `msg_valid` are 0.
- R2: Input line 0 drives pin 2 (ORed with line 2), pin 0 is never driven by any line, and every other line N drives pin N.
- R3: For a level pin (`ent_level`=1), the pending bit follows the pin's input one cycle later: a high input sets it and a low input clears it.
- R4: For an edge pin (`ent_level`=0), a rising input sets the pending bit only when the pin is unmasked (`ent_mask`=0). A rising input on a masked edge pin is dropped and never produces a message.
- R5: A masked pin produces no message, and its pending bit stays set.
- R6: Dispatching an edge pin clears its pending bit.
- R7: Dispatching a level pin sets its remote-IRR bit. While that bit is set, the pin produces no further message. A `rirr_clr` strobe with `rirr_clr_idx` equal to the pin clears the bit and restarts the scan, so a pin whose input is still high is sent again.
- R8: `msg_addr` = 0xFEE00000 with the destination index in bits [19:4] and the destination mode in bit 2. `msg_data` holds the vector in [7:0], the delivery mode in [10:8] and the trigger mode (1 = level) in bit 15. All other bits are 0.
- R9: When a pin's delivery mode is 3'b111 (external interrupt), the data vector field is taken from `ext_vector` and not from the entry.
- R10: When several pins are eligible, messages are sent in ascending pin order.
- R11: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold steady.
- R12: Unmasking a pin that already has a pending bit does not start a scan by itself. A `scan_req` pulse starts one.
- R13: If a new rising edge reaches an edge pin in the same cycle that the pin's pending request is dispatched, the pending bit stays set and a further message follows.
- R14: A pin configured as edge-triggered reads its remote-IRR bit as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_i | input | NUM_PINS | Interrupt input lines |
| ent_vector | input | NUM_PINS*8 | Per-pin vector, pin p at [p*8 +: 8] |
| ent_dlv | input | NUM_PINS*3 | Per-pin delivery mode, pin p at [p*3 +: 3] |
| ent_dmode | input | NUM_PINS | Per-pin destination mode |
| ent_dest | input | NUM_PINS*16 | Per-pin destination index, pin p at [p*16 +: 16] |
| ent_level | input | NUM_PINS | Per-pin trigger mode, 1 = level, 0 = edge |
| ent_mask | input | NUM_PINS | Per-pin mask, 1 = masked |
| ext_vector | input | 8 | Vector used for the external-interrupt delivery mode |
| rirr_clr | input | 1 | Strobe that clears one pin's remote-IRR bit |
| rirr_clr_idx | input | $clog2(NUM_PINS) | Pin whose remote-IRR bit is cleared |
| scan_req | input | 1 | Strobe that starts a new scan |
| msg_valid | output | 1 | A message is presented |
| msg_ready | input | 1 | The consumer accepts the message |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |
| pend_bits | output | NUM_PINS | Per-pin pending-request bits |
| rirr_bits | output | NUM_PINS | Per-pin remote-IRR bits |

## Verification
The case to probe is a new edge arriving on a pin in the same cycle that the pin's earlier request is dispatched. In that cycle the dispatch wants to clear the pending bit and the capture wants to set it. The bench holds one message from the pin on an unready port and queues a second request. It then releases the port and raises the line again in the exact cycle the second dispatch is registered. The check passes only if the pending bit is still set one cycle later and a third message follows.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;

  localparam int VEC_W  = 8;
  localparam int DLV_W  = 3;
  localparam int DEST_W = 16;

  localparam logic [11:0]      ADDR_BASE_HI = 12'hFEE;
  localparam logic [DLV_W-1:0] DLV_EXTINT   = 3'b111;

  // Address: base in [31:20], destination index [19:4], mode bit 2
  function automatic logic [31:0] build_addr(input logic [DEST_W-1:0] dest,
                                             input logic dmode);
    return {ADDR_BASE_HI, dest, 1'b0, dmode, 2'b00};
  endfunction

  // Data: trigger bit 15, delivery mode [10:8], vector [7:0]
  function automatic logic [31:0] build_data(input logic [VEC_W-1:0] vec,
                                             input logic [DLV_W-1:0] dlv,
                                             input logic level);
    return {16'h0000, level, 4'h0, dlv, vec};
  endfunction

endpackage

// File: rtl/irq_route.sv
module irq_route #(
  parameter int NUM_PINS = 24
) (
  input  logic [NUM_PINS-1:0] line_i,
  output logic [NUM_PINS-1:0] pin_in_o
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    if (p == 0) begin : g_zero
      assign pin_in_o[p] = 1'b0;
    end else if (p == 2) begin : g_two
      assign pin_in_o[p] = line_i[0] | line_i[2];
    end else begin : g_direct
      assign pin_in_o[p] = line_i[p];
    end
  end

endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] ent_level,
  input  logic [NUM_PINS-1:0] ent_mask,
  input  logic [NUM_PINS-1:0] launch_oh,
  input  logic                rirr_clr,
  input  logic [IDX_W-1:0]    rirr_clr_idx,
  output logic [NUM_PINS-1:0] pend_o,
  output logic [NUM_PINS-1:0] rirr_o,
  output logic [NUM_PINS-1:0] new_req_o,
  output logic [NUM_PINS-1:0] edge_set_o
);

  logic [NUM_PINS-1:0] in_q;
  logic [NUM_PINS-1:0] pend_n;
  logic [NUM_PINS-1:0] rirr_n;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic clr_hit;
    assign clr_hit       = rirr_clr && (rirr_clr_idx == IDX_W'(p));
    assign edge_set_o[p] = pin_in[p] & ~in_q[p] & ~ent_mask[p] & ~ent_level[p];

    always_comb begin
      if (ent_level[p]) begin
        pend_n[p] = pin_in[p];
      end else begin
        pend_n[p] = (pend_o[p] & ~launch_oh[p]) | edge_set_o[p];
      end
      rirr_n[p] = ((rirr_o[p] & ~clr_hit) | (launch_oh[p] & ent_level[p]))
                  & ent_level[p];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        in_q[p]   <= 1'b0;
        pend_o[p] <= 1'b0;
        rirr_o[p] <= 1'b0;
      end else begin
        in_q[p]   <= pin_in[p];
        pend_o[p] <= pend_n[p];
        rirr_o[p] <= rirr_n[p];
      end
    end
  end

  assign new_req_o = pend_n & ~pend_o;

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = $clog2(NUM_PINS)
) (
  input  logic [NUM_PINS-1:0] elig,
  output logic                found,
  output logic [IDX_W-1:0]    idx,
  output logic [NUM_PINS-1:0] onehot
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  assign onehot = elig & (~elig + NUM_PINS'(1));

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PINS-1:0]        line_i,
  input  logic [NUM_PINS*VEC_W-1:0]  ent_vector,
  input  logic [NUM_PINS*DLV_W-1:0]  ent_dlv,
  input  logic [NUM_PINS-1:0]        ent_dmode,
  input  logic [NUM_PINS*DEST_W-1:0] ent_dest,
  input  logic [NUM_PINS-1:0]        ent_level,
  input  logic [NUM_PINS-1:0]        ent_mask,
  input  logic [VEC_W-1:0]           ext_vector,
  input  logic                       rirr_clr,
  input  logic [IDX_W-1:0]           rirr_clr_idx,
  input  logic                       scan_req,
  output logic                       msg_valid,
  input  logic                       msg_ready,
  output logic [31:0]                msg_addr,
  output logic [31:0]                msg_data,
  output logic [NUM_PINS-1:0]        pend_bits,
  output logic [NUM_PINS-1:0]        rirr_bits
);

  logic [NUM_PINS-1:0] pin_in;
  logic [NUM_PINS-1:0] new_req;
  logic [NUM_PINS-1:0] edge_set;
  logic [NUM_PINS-1:0] elig;
  logic [NUM_PINS-1:0] pick_oh;
  logic [NUM_PINS-1:0] launch_oh;
  logic                found;
  logic [IDX_W-1:0]    pick_idx;
  logic                armed;
  logic                launch;
  logic                arm_evt;

  logic [VEC_W-1:0]    sel_vec;
  logic [DLV_W-1:0]    sel_dlv;
  logic [DEST_W-1:0]   sel_dest;
  logic                sel_dmode;
  logic                sel_level;

  irq_route #(.NUM_PINS(NUM_PINS)) u_route (
    .line_i   (line_i),
    .pin_in_o (pin_in)
  );

  irq_pend #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_pend (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_in       (pin_in),
    .ent_level    (ent_level),
    .ent_mask     (ent_mask),
    .launch_oh    (launch_oh),
    .rirr_clr     (rirr_clr),
    .rirr_clr_idx (rirr_clr_idx),
    .pend_o       (pend_bits),
    .rirr_o       (rirr_bits),
    .new_req_o    (new_req),
    .edge_set_o   (edge_set)
  );

  // Eligible: pending, unmasked, and (edge or remote-IRR clear)
  assign elig = pend_bits & ~ent_mask & (~ent_level | ~rirr_bits);

  irq_pick #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_pick (
    .elig   (elig),
    .found  (found),
    .idx    (pick_idx),
    .onehot (pick_oh)
  );

  assign launch    = armed & ~msg_valid & found;
  assign launch_oh = launch ? pick_oh : '0;
  assign arm_evt   = (|new_req) | rirr_clr | scan_req;

  always_comb begin
    sel_vec   = ent_vector[int'(pick_idx)*VEC_W +: VEC_W];
    sel_dlv   = ent_dlv[int'(pick_idx)*DLV_W +: DLV_W];
    sel_dest  = ent_dest[int'(pick_idx)*DEST_W +: DEST_W];
    sel_dmode = ent_dmode[pick_idx];
    sel_level = ent_level[pick_idx];
    if (sel_dlv == DLV_EXTINT) begin
      sel_vec = ext_vector;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (arm_evt) begin
      armed <= 1'b1;
    end else if (!msg_valid && !found) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (launch) begin
      msg_valid <= 1'b1;
      msg_addr  <= build_addr(sel_dest, sel_dmode);
      msg_data  <= build_data(sel_vec, sel_dlv, sel_level);
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
  parameter int NUM_PINS = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic [31:0]         msg_addr,
  input logic [31:0]         msg_data,
  input logic [NUM_PINS-1:0] pend_bits,
  input logic [NUM_PINS-1:0] rirr_bits,
  input logic [NUM_PINS-1:0] launch_oh,
  input logic [NUM_PINS-1:0] ent_level,
  input logic [NUM_PINS-1:0] ent_mask
);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  assert_single_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(launch_oh));

  assert_masked_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_oh & ent_mask) == '0);

  assert_level_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_oh & ent_level & rirr_bits) == '0);

  assert_level_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(launch_oh & ent_level)) |=> ((rirr_bits & $past(launch_oh & ent_level)) != '0));

  assert_masked_edge_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_bits & ~$past(pend_bits) & ~$past(ent_level) & $past(ent_mask)) == '0);

  assert_edge_no_rirr_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (rirr_bits & ~ent_level & $past(~ent_level)) == '0);

endmodule

bind irq_dispatch irq_dispatch_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_addr  (msg_addr),
  .msg_data  (msg_data),
  .pend_bits (pend_bits),
  .rirr_bits (rirr_bits),
  .launch_oh (launch_oh),
  .ent_level (ent_level),
  .ent_mask  (ent_mask)
);

// File: tb/test_irq_dispatch.sv
module test_irq_dispatch;

  localparam int NP = 24;
  localparam int IW = $clog2(NP);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NP-1:0]  line_i = '0;
  logic [NP*8-1:0]  ent_vector = '0;
  logic [NP*3-1:0]  ent_dlv = '0;
  logic [NP-1:0]    ent_dmode = '0;
  logic [NP*16-1:0] ent_dest = '0;
  logic [NP-1:0]    ent_level = '0;
  logic [NP-1:0]    ent_mask = '0;
  logic [7:0]       ext_vector = '0;
  logic             rirr_clr = 1'b0;
  logic [IW-1:0]    rirr_clr_idx = '0;
  logic             scan_req = 1'b0;
  logic             msg_ready = 1'b0;
  logic             msg_valid;
  logic [31:0]      msg_addr;
  logic [31:0]      msg_data;
  logic [NP-1:0]    pend_bits;
  logic [NP-1:0]    rirr_bits;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_dispatch #(.NUM_PINS(NP)) i_irq_dispatch (
    .clk(clk), .rst_n(rst_n), .line_i(line_i),
    .ent_vector(ent_vector), .ent_dlv(ent_dlv), .ent_dmode(ent_dmode),
    .ent_dest(ent_dest), .ent_level(ent_level), .ent_mask(ent_mask),
    .ext_vector(ext_vector), .rirr_clr(rirr_clr), .rirr_clr_idx(rirr_clr_idx),
    .scan_req(scan_req), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data),
    .pend_bits(pend_bits), .rirr_bits(rirr_bits)
  );

  function automatic logic [31:0] want_addr(int dest, int dmode);
    return 32'hFEE0_0000 + 32'(dest) * 32'd16 + 32'(dmode) * 32'd4;
  endfunction

  function automatic logic [31:0] want_data(int vec, int dlv, int lvl);
    return 32'(vec) + 32'(dlv) * 32'd256 + 32'(lvl) * 32'd32768;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic set_pin(int p, int vec, int dlv, int dmode, int dest, int lvl, int msk);
    ent_vector[p*8 +: 8]   = 8'(vec);
    ent_dlv[p*3 +: 3]      = 3'(dlv);
    ent_dmode[p]           = 1'(dmode);
    ent_dest[p*16 +: 16]   = 16'(dest);
    ent_level[p]           = 1'(lvl);
    ent_mask[p]            = 1'(msk);
  endtask

  task automatic pulse_line(int p);
    @(negedge clk) line_i[p] = 1'b1;
    @(negedge clk) line_i[p] = 1'b0;
  endtask

  task automatic wait_valid(string tag);
    for (int k = 0; k < 30 && !msg_valid; k++) @(negedge clk);
    check({tag, " valid"}, 32'(msg_valid), 32'd1);
  endtask

  task automatic handshake();
    msg_ready = 1'b1;
    @(negedge clk) msg_ready = 1'b0;
  endtask

  task automatic expect_msg(string tag, logic [31:0] a, logic [31:0] d);
    wait_valid(tag);
    check({tag, " addr"}, msg_addr, a);
    check({tag, " data"}, msg_data, d);
    handshake();
  endtask

  task automatic expect_none(string tag, int n);
    logic seen = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
    check({tag, " no message"}, 32'(seen), 32'd0);
  endtask

  task automatic pulse_clr(int p);
    @(negedge clk) begin rirr_clr = 1'b1; rirr_clr_idx = IW'(p); end
    @(negedge clk) rirr_clr = 1'b0;
  endtask

  task automatic pulse_scan();
    @(negedge clk) scan_req = 1'b1;
    @(negedge clk) scan_req = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 pend", 32'(pend_bits), 32'd0);
    check("R1 rirr", 32'(rirr_bits), 32'd0);
    check("R1 valid", 32'(msg_valid), 32'd0);
  endtask

  task automatic t_edge_basic();
    set_pin(5, 'h41, 0, 1, 'h00AB, 0, 0);
    pulse_line(5);
    expect_msg("R8 R4 edge pin5", want_addr('h00AB, 1), want_data('h41, 0, 0));
    check("R6 pend cleared", 32'(pend_bits[5]), 32'd0);
  endtask

  task automatic t_masked_edge();
    set_pin(6, 'h66, 0, 0, 'h0001, 0, 1);
    pulse_line(6);
    @(negedge clk);
    check("R4 masked edge dropped", 32'(pend_bits[6]), 32'd0);
    ent_mask[6] = 1'b0;
    pulse_scan();
    expect_none("R4 masked edge", 10);
  endtask

  task automatic t_route();
    set_pin(2, 'h22, 0, 0, 'h0202, 0, 0);
    set_pin(0, 'h10, 0, 0, 'h0000, 0, 0);
    pulse_line(0);
    expect_msg("R2 line0 to pin2", want_addr('h0202, 0), want_data('h22, 0, 0));
    check("R2 pin0 idle", 32'(pend_bits[0]), 32'd0);
    expect_none("R2 single message", 6);
  endtask

  task automatic t_level();
    set_pin(9, 'h90, 1, 0, 'h1234, 1, 0);
    @(negedge clk) line_i[9] = 1'b1;
    @(negedge clk);
    check("R3 level pend set", 32'(pend_bits[9]), 32'd1);
    expect_msg("R8 level pin9", want_addr('h1234, 0), want_data('h90, 1, 1));
    check("R7 rirr set", 32'(rirr_bits[9]), 32'd1);
    expect_none("R7 coalesced", 10);
    pulse_clr(9);
    expect_msg("R7 resend after clear", want_addr('h1234, 0), want_data('h90, 1, 1));
    @(negedge clk) line_i[9] = 1'b0;
    @(negedge clk);
    check("R3 level pend cleared", 32'(pend_bits[9]), 32'd0);
    check("R14 rirr before switch", 32'(rirr_bits[9]), 32'd1);
    ent_level[9] = 1'b0;
    @(negedge clk);
    check("R14 edge rirr zero", 32'(rirr_bits[9]), 32'd0);
  endtask

  task automatic t_mask_level();
    set_pin(12, 'hC0, 0, 1, 'h0C0C, 1, 1);
    @(negedge clk) line_i[12] = 1'b1;
    expect_none("R5 masked level", 8);
    check("R5 pend kept", 32'(pend_bits[12]), 32'd1);
    ent_mask[12] = 1'b0;
    expect_none("R12 unmask alone", 10);
    pulse_scan();
    expect_msg("R12 scan request", want_addr('h0C0C, 1), want_data('hC0, 0, 1));
    @(negedge clk) line_i[12] = 1'b0;
    pulse_clr(12);
    expect_none("R12 settle", 4);
  endtask

  task automatic t_extint();
    set_pin(7, 'h33, 7, 0, 'h0007, 0, 0);
    ext_vector = 8'hC5;
    pulse_line(7);
    expect_msg("R9 external vector", want_addr('h0007, 0), want_data('hC5, 7, 0));
  endtask

  task automatic t_order();
    set_pin(4, 'h44, 0, 0, 'h0004, 0, 0);
    set_pin(14, 'hE4, 2, 1, 'h000E, 0, 0);
    @(negedge clk) begin line_i[4] = 1'b1; line_i[14] = 1'b1; end
    @(negedge clk) begin line_i[4] = 1'b0; line_i[14] = 1'b0; end
    wait_valid("R10 first");
    check("R10 lower pin first", msg_data, want_data('h44, 0, 0));
    for (int k = 0; k < 3; k++) @(negedge clk);
    check("R11 valid held", 32'(msg_valid), 32'd1);
    check("R11 addr held", msg_addr, want_addr('h0004, 0));
    check("R11 data held", msg_data, want_data('h44, 0, 0));
    handshake();
    expect_msg("R10 higher pin next", want_addr('h000E, 1), want_data('hE4, 2, 0));
  endtask

  task automatic t_collide();
    set_pin(5, 'h55, 0, 0, 'h0005, 0, 0);
    pulse_line(5);
    wait_valid("R13 first");
    pulse_line(5);
    check("R13 queued", 32'(pend_bits[5]), 32'd1);
    msg_ready = 1'b1;
    @(negedge clk) begin msg_ready = 1'b0; line_i[5] = 1'b1; end
    @(negedge clk) line_i[5] = 1'b0;
    check("R13 second sent", 32'(msg_valid), 32'd1);
    check("R13 pend kept", 32'(pend_bits[5]), 32'd1);
    handshake();
    expect_msg("R13 third message", want_addr('h0005, 0), want_data('h55, 0, 0));
    expect_none("R13 drained", 6);
  endtask

  initial begin
    for (int p = 0; p < NP; p++) set_pin(p, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_edge_basic();
    t_masked_edge();
    t_route();
    t_level();
    t_mask_level();
    t_extint();
    t_order();
    t_collide();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule